// File: doc/BRIEF.md
# Supervisor Interrupt Poll Sequencer

This block sits on the supervisor side of a shared bus. Devices signal it over two wired-OR, active-low lines. The take-over line reports that a master has finished its task or that a device has hit an error, such as a hardware fault or a parity failure. The service-request line reports that a device wants attention, for example because an offline job it was given has completed. Neither line says which device is asking, so the block finds out by polling. It walks device addresses one at a time and hands each address to an external bus transaction engine. It then reads back whether that device is requesting, and flags each device that needs service together with the line that caused the poll.

Polling is repeated, wrapping around the address space, for as long as the line being served stays asserted. The take-over line always wins over the service-request line, and it can preempt a service-request scan that is already running. Only the service-request line can be masked. Both lines are synchronized through two flops before use. The sequencer goes back to idle once it has sampled the served line released at a poll response.

Top module: `sip_irq_poller`

## Requirements
- R1: While reset is asserted and afterwards with both lines high, `idle_o` is 1, and `poll_stb_o` and `svc_o` are 0.
- R2: A line is asserted when low. Each line passes through a two-flop synchronizer, so a fall on an idle block produces the first `poll_stb_o` on the third clock edge after the fall, and not before.
- R3: A scan starts at address 0 and advances by one address per poll. `poll_stb_o` is high for exactly one cycle for each poll, with the address on `poll_addr_o`.
- R4: `svc_o` is high in exactly the cycle where `resp_valid_i` and `resp_req_i` are both high for an outstanding poll. In that cycle `poll_addr_o` gives the device, and `svc_cause_o` gives the line, where 0 means take-over and 1 means service request.
- R5: After polling address N_DEV-1, if the served line is still asserted, polling continues at address 0.
- R6: At each poll response the block samples the served line. If it is released, the block returns to idle with no further poll. If it is still asserted, the next poll follows.
- R7: When both lines are pending while idle, the take-over line is served first.
- R8: If the take-over line is asserted when a response arrives during a service-request scan, the scan restarts at address 0 with cause take-over.
- R9: While `sr_mask_i` is 1, the service-request line starts no scan, and a running service-request scan ends at its next response. The take-over line is never masked.
- R10: No new poll is issued while a poll's response is outstanding. A `resp_valid_i` with no poll outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| to_n_i | input | 1 | Take-over line, wired-OR, active low |
| sr_n_i | input | 1 | Service-request line, wired-OR, active low |
| sr_mask_i | input | 1 | 1 masks the service-request line |
| resp_valid_i | input | 1 | Poll response strobe from the transaction engine |
| resp_req_i | input | 1 | Polled device is requesting (valid with resp_valid_i) |
| poll_stb_o | output | 1 | One-cycle request to poll poll_addr_o |
| poll_addr_o | output | ADDR_W | Device address being polled |
| svc_o | output | 1 | Polled device needs service |
| svc_cause_o | output | 1 | Line being served: 0 take-over, 1 service request |
| idle_o | output | 1 | No scan in progress |

## Verification
Four properties are checked on every cycle: the strobe lasts a single cycle, no poll is issued while a response is outstanding, addresses step by one or wrap to zero and start at zero after idle, and a service flag never appears without a requesting response. The following can only be shown by the bench's scenarios: the three-edge synchronizer latency, priority when both lines are pending, preemption of a running service-request scan, masking, and the rule that the block ends a scan only after it has sampled the line released. The bench runs a device model whose requests clear as each device is serviced, and it checks the exact order of polls and service flags.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} poll_st_e;
  typedef enum logic {CAUSE_TO = 1'b0, CAUSE_SR = 1'b1} irq_cause_e;
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= RST_VAL;
    else         st_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL;
      else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sip_addr_ctr.sv
module sip_addr_ctr #(
  parameter int unsigned N_DEV  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(N_DEV - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= (addr_q == LastAddr) ? '0 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/sip_poll_ctrl.sv
module sip_poll_ctrl
  import sip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic to_act_i,
  input  logic sr_act_i,
  input  logic sr_mask_i,
  input  logic resp_valid_i,
  input  logic resp_req_i,
  output logic clr_o,
  output logic inc_o,
  output logic stb_o,
  output logic svc_o,
  output logic cause_o,
  output logic idle_o
);
  poll_st_e   st_q, st_d;
  irq_cause_e cause_q, cause_d;
  logic       sr_ok;

  assign sr_ok = sr_act_i && !sr_mask_i;

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (to_act_i) begin
          st_d = ST_ISSUE; cause_d = CAUSE_TO; clr_o = 1'b1;
        end else if (sr_ok) begin
          st_d = ST_ISSUE; cause_d = CAUSE_SR; clr_o = 1'b1;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (resp_valid_i) begin
          if (to_act_i) begin
            st_d = ST_ISSUE;
            // take-over preempts a service-request scan from address 0
            if (cause_q == CAUSE_SR) begin
              cause_d = CAUSE_TO; clr_o = 1'b1;
            end else begin
              inc_o = 1'b1;
            end
          end else if (cause_q == CAUSE_SR && sr_ok) begin
            st_d = ST_ISSUE; inc_o = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cause_q <= CAUSE_TO;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
    end
  end

  assign stb_o   = (st_q == ST_ISSUE);
  assign svc_o   = (st_q == ST_WAIT) && resp_valid_i && resp_req_i;
  assign cause_o = cause_q;
  assign idle_o  = (st_q == ST_IDLE);
endmodule

// File: rtl/sip_irq_poller.sv
module sip_irq_poller #(
  parameter int unsigned N_DEV    = 8,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned ADDR_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              to_n_i,
  input  logic              sr_n_i,
  input  logic              sr_mask_i,
  input  logic              resp_valid_i,
  input  logic              resp_req_i,
  output logic              poll_stb_o,
  output logic [ADDR_W-1:0] poll_addr_o,
  output logic              svc_o,
  output logic              svc_cause_o,
  output logic              idle_o
);
  logic [1:0] line_s;
  logic       clr, inc;

  sip_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sr_n_i, to_n_i}),
    .q_o    (line_s)
  );

  sip_poll_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .to_act_i     (~line_s[0]),
    .sr_act_i     (~line_s[1]),
    .sr_mask_i    (sr_mask_i),
    .resp_valid_i (resp_valid_i),
    .resp_req_i   (resp_req_i),
    .clr_o        (clr),
    .inc_o        (inc),
    .stb_o        (poll_stb_o),
    .svc_o        (svc_o),
    .cause_o      (svc_cause_o),
    .idle_o       (idle_o)
  );

  sip_addr_ctr #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .addr_o (poll_addr_o)
  );
endmodule

// File: rtl/sip_poller_chk.sv
module sip_poller_chk #(
  parameter int unsigned N_DEV  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              poll_stb_o,
  input logic [ADDR_W-1:0] poll_addr_o,
  input logic              svc_o,
  input logic              idle_o,
  input logic              resp_valid_i,
  input logic              resp_req_i
);
  logic              pend_q, have_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      have_q <= 1'b0;
      last_q <= '0;
    end else begin
      if (poll_stb_o)        pend_q <= 1'b1;
      else if (resp_valid_i) pend_q <= 1'b0;
      if (idle_o) have_q <= 1'b0;
      else if (poll_stb_o) begin
        have_q <= 1'b1;
        last_q <= poll_addr_o;
      end
    end
  end

  // R3
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_stb_o |=> !poll_stb_o);

  // R3
  first_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_stb_o && $past(idle_o)) |-> (poll_addr_o == '0));

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_stb_o && have_q) |->
      (poll_addr_o == '0 || poll_addr_o == ADDR_W'(last_q + 1'b1)));

  // R10
  no_stb_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_stb_o |-> !pend_q);

  // R4
  svc_needs_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> (resp_valid_i && resp_req_i && pend_q));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!poll_stb_o && !svc_o));
endmodule

bind sip_irq_poller sip_poller_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .poll_stb_o   (poll_stb_o),
  .poll_addr_o  (poll_addr_o),
  .svc_o        (svc_o),
  .idle_o       (idle_o),
  .resp_valid_i (resp_valid_i),
  .resp_req_i   (resp_req_i)
);

// File: tb/sip_irq_poller_tb_top.sv
module sip_irq_poller_tb_top;
  localparam int N  = 8;
  localparam int AW = 3;

  typedef struct packed {
    logic          is_svc;
    logic [AW-1:0] addr;
    logic          cause;
  } ev_t;

  logic clk_i = 1'b0;
  logic rst_n = 1'b0;
  logic sr_mask_i = 1'b0;
  logic resp_valid_i = 1'b0;
  logic resp_req_i = 1'b0;
  logic poll_stb_o, svc_o, svc_cause_o, idle_o;
  logic [AW-1:0] poll_addr_o;

  // device model: main raises, monitor marks done / applies hooks
  logic [N-1:0] to_raise = '0, to_hook = '0, to_done = '0;
  logic [N-1:0] sr_raise = '0, sr_done = '0;
  logic stuck_on = 1'b0, stuck_off = 1'b0;
  logic [N-1:0] to_act, sr_act;
  logic to_n_i, sr_n_i;

  assign to_act = (to_raise | to_hook) & ~to_done;
  assign sr_act = sr_raise & ~sr_done;
  assign to_n_i = ~(|to_act | (stuck_on & ~stuck_off));
  assign sr_n_i = ~(|sr_act);

  int vectors = 0;
  int fails   = 0;
  ev_t exp_q[$];

  int hook_kind = 0;
  int hook_skip = 0;
  logic [AW-1:0] hook_addr = '0;
  logic hook_cause = 1'b0;
  int rsp_cnt = 0;
  logic [AW-1:0] rsp_addr = '0;

  always #4 clk_i = ~clk_i;

  sip_irq_poller #(.N_DEV(N)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .to_n_i       (to_n_i),
    .sr_n_i       (sr_n_i),
    .sr_mask_i    (sr_mask_i),
    .resp_valid_i (resp_valid_i),
    .resp_req_i   (resp_req_i),
    .poll_stb_o   (poll_stb_o),
    .poll_addr_o  (poll_addr_o),
    .svc_o        (svc_o),
    .svc_cause_o  (svc_cause_o),
    .idle_o       (idle_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_scan(input logic cause, input int first, input int last,
                           input logic [N-1:0] req);
    for (int a = first; a <= last; a++) begin
      exp_q.push_back('{is_svc: 1'b0, addr: AW'(a), cause: cause});
      if (req[a]) exp_q.push_back('{is_svc: 1'b1, addr: AW'(a), cause: cause});
    end
  endtask

  task automatic compare_ev(input logic is_svc, input string req);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, req, is_svc ? "unexpected service flag at addr" : "unexpected poll at addr",
          int'(poll_addr_o), -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.is_svc == is_svc, req, "event kind", int'(is_svc), int'(e.is_svc));
      chk(e.addr == poll_addr_o, req, "address", int'(poll_addr_o), int'(e.addr));
      chk(e.cause == svc_cause_o, req, "cause", int'(svc_cause_o), int'(e.cause));
    end
  endtask

  // monitor + poll responder
  always @(negedge clk_i) begin
    if (rst_n) begin
      resp_valid_i = 1'b0;
      resp_req_i   = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          resp_valid_i = 1'b1;
          resp_req_i   = svc_cause_o ? sr_act[rsp_addr] : to_act[rsp_addr];
        end
      end
      if (poll_stb_o) begin
        chk(rsp_cnt == 0, "R10", "poll while response outstanding", rsp_cnt, 0);
        compare_ev(1'b0, "R3");
        if (hook_kind != 0 && poll_addr_o == hook_addr && svc_cause_o == hook_cause) begin
          if (hook_skip > 0) hook_skip--;
          else begin
            if (hook_kind == 1) stuck_off = 1'b1;
            else                to_hook[1] = 1'b1;
            hook_kind = 0;
          end
        end
        rsp_cnt  = 2;
        rsp_addr = poll_addr_o;
      end
      #1;
      if (svc_o) begin
        compare_ev(1'b1, "R4");
        if (svc_cause_o) sr_done[poll_addr_o] = 1'b1;
        else             to_done[poll_addr_o] = 1'b1;
      end
    end
  end

  task automatic wait_idle(input string req);
    int t = 0;
    while ((exp_q.size() != 0 || !idle_o) && t < 400) begin
      @(negedge clk_i);
      t++;
    end
    repeat (8) @(negedge clk_i);
    chk(exp_q.size() == 0, req, "events still expected", exp_q.size(), 0);
    chk(idle_o == 1'b1, req, "idle after line released", int'(idle_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 under reset
    chk(idle_o == 1'b1, "R1", "idle in reset", int'(idle_o), 1);
    chk(poll_stb_o == 1'b0, "R1", "strobe in reset", int'(poll_stb_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(idle_o == 1'b1 && !poll_stb_o && !svc_o, "R1", "quiet after reset",
        int'({idle_o, poll_stb_o, svc_o}), 4);

    // R2 latency, R3/R4/R6 basic take-over scan, device 3
    push_scan(1'b0, 0, 4, N'(1) << 3);
    to_raise[3] = 1'b1;
    @(negedge clk_i);
    chk(!poll_stb_o, "R2", "strobe after 1 edge", int'(poll_stb_o), 0);
    @(negedge clk_i);
    chk(!poll_stb_o, "R2", "strobe after 2 edges", int'(poll_stb_o), 0);
    @(negedge clk_i);
    chk(poll_stb_o, "R2", "strobe after 3 edges", int'(poll_stb_o), 1);
    wait_idle("R6");

    // R5 wrap: line held with no requester for a full round
    push_scan(1'b0, 0, N - 1, '0);
    push_scan(1'b0, 0, 0, '0);
    hook_kind = 1; hook_addr = '0; hook_cause = 1'b0; hook_skip = 1;
    stuck_on = 1'b1;
    wait_idle("R5");

    // R9 mask holds off the service-request line
    sr_mask_i = 1'b1;
    sr_raise[2] = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(idle_o == 1'b1, "R9", "idle while masked", int'(idle_o), 1);
    push_scan(1'b1, 0, 3, N'(1) << 2);
    sr_mask_i = 1'b0;
    wait_idle("R9");

    // R9 take-over ignores the mask
    sr_mask_i = 1'b1;
    push_scan(1'b0, 0, 1, N'(1) << 0);
    to_raise[0] = 1'b1;
    wait_idle("R9");
    sr_mask_i = 1'b0;

    // R7 both pending: take-over first
    push_scan(1'b0, 0, 3, N'(1) << 2);
    push_scan(1'b1, 0, 2, N'(1) << 1);
    to_raise[2] = 1'b1;
    sr_raise[1] = 1'b1;
    wait_idle("R7");

    // R8 take-over preempts a running service-request scan
    push_scan(1'b1, 0, 2, '0);
    push_scan(1'b0, 0, 2, N'(1) << 1);
    push_scan(1'b1, 0, 6, N'(1) << 5);
    hook_kind = 2; hook_addr = AW'(2); hook_cause = 1'b1; hook_skip = 0;
    sr_raise[5] = 1'b1;
    wait_idle("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule